// File: doc/BRIEF.md
# Serial Register Access Slave

This block is a four-wire serial slave. It gives a host read and write access to a small bank of 8-bit control registers. The host lowers an active-low select, then sends a 16-clock frame on the serial clock. The first bit is the direction flag. The next seven bits are the address and the last eight bits are the data. Address and data each go least significant bit first. In a read frame the block returns the addressed register on serial data out during the data phase. In a write frame it commits the received byte once the final data bit arrives.

The bank has five general 8-bit registers at indices 0 to 4. Index 5 holds a 5-bit output-control register that steers a downstream clock generator: two divide-by-8 selects and three output enables. Indices 6 and 7 are reserved. The register contents are brought out as parallel outputs. The serial pins are oversampled by a faster system clock, so the whole block runs on that one clock. Serial data out is given as a data bit and a separate drive enable, and a pad cell outside the block turns these into a tri-state pin.

Top module: `sra_serial_regs`

## Requirements
- R1: A frame is the direction flag on the 1st serial clock, address bits A0..A6 on the 2nd to 8th, and data bits D0..D7 on the 9th to 16th, each field least significant bit first. A flag of 1 means read and a flag of 0 means write.
- R2: A write to index 0..4 stores all 8 data bits. A later read of that index returns them, and they appear on `gp_regs` at bits [8*i+7 : 8*i].
- R3: Index 5 stores only data bits D0..D4. A read of index 5 returns D5..D7 as 0.
- R4: The index-5 bits drive the control pins in this order: bit 0 `out1_div8`, bit 1 `out2_div8`, bit 2 `out2_en`, bit 3 `out1_en`, bit 4 `frame8k_en`.
- R5: Indices 6 and 7 are reserved. Writes to them change no register, and reads of them return 0x00.
- R6: Address bit A6 is ignored. Addresses 0x41 and 0x01 select the same register.
- R7: If any of the address bits A3..A5 is 1, no register is selected. Such a write is ignored and such a read returns 0x00.
- R8: `sdo_oe` is low during the flag and address bits, and low for the whole of a write frame. In a read frame it is high from the falling serial clock edge after the 8th rising edge until the falling edge after the 16th rising edge. It is low whenever select is high.
- R9: A write commits only after the 16th rising serial clock edge. If select rises earlier, the frame is discarded and no register changes.
- R10: Serial clocks after the 16th within one frame are ignored.
- R11: Reset clears all registers and control pins to 0 and sets `sdo_oe` low.
- R12: Serial data in is sampled on rising serial clock edges. Serial data out changes only after falling serial clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out value |
| sdo_oe | output | 1 | Drive enable for serial data out; pin is high-impedance when low |
| gp_regs | output | 40 | General registers 0..4, packed with index 0 in the low byte |
| out1_div8 | output | 1 | Divide-by-8 select for clock output 1 |
| out2_div8 | output | 1 | Divide-by-8 select for clock output 2 |
| out2_en | output | 1 | Enable for clock output 2 |
| out1_en | output | 1 | Enable for clock output 1 |
| frame8k_en | output | 1 | Enable for the 8 kHz frame sync output |

## Verification
Each serial pin passes through a two-stage synchronizer and an edge detector. Because of this, a read bit reaches `sdo` three system clocks after the falling serial edge. A committed write reaches the parallel outputs about five system clocks after the 16th rising edge. The bench holds each serial clock phase for eight system clocks. It samples `sdo` and `sdo_oe` at the end of the low phase, just before the next rising edge, and it checks the parallel outputs only after select has been high for eight more clocks. All stimulus changes and all samples fall on the system clock's falling edge, well clear of those latencies.

// File: rtl/sra_pkg.sv
package sra_pkg;
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 7;
  localparam int DEC_W      = ADDR_W - 1;
  localparam int SEL_W      = 3;
  localparam int NUM_GP     = 5;
  localparam int CTL_IDX    = 5;
  localparam int CTL_W      = 5;
  localparam int FRAME_BITS = 1 + ADDR_W + DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam int DIDX_W     = $clog2(DATA_W);
  localparam int AIDX_W     = $clog2(DEC_W);

  // control register bit positions, decoded by the clock generator
  localparam int CB_OUT1_DIV8 = 0;
  localparam int CB_OUT2_DIV8 = 1;
  localparam int CB_OUT2_EN   = 2;
  localparam int CB_OUT1_EN   = 3;
  localparam int CB_FRAME8K   = 4;

  typedef struct packed {
    logic              en;
    logic [DEC_W-1:0]  addr;
    logic [DATA_W-1:0] data;
  } wr_req_t;
endpackage

// File: rtl/sra_sync.sv
module sra_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stg_d;
    if (s == 0) begin : g_first
      assign stg_d = d;
    end else begin : g_next
      assign stg_d = stg_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= RST_VAL;
      else        stg_q[s] <= stg_d;
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/sra_frame.sv
module sra_frame
  import sra_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_s,
  input  logic              sclk_s,
  input  logic              sdi_s,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DEC_W-1:0]  rd_addr,
  output wr_req_t           wr_req,
  output logic              sdo,
  output logic              sdo_oe
);
  localparam logic [CNT_W-1:0] CNT_ADDR_END = CNT_W'(DEC_W);
  localparam logic [CNT_W-1:0] CNT_DATA0    = CNT_W'(1 + ADDR_W);
  localparam logic [CNT_W-1:0] CNT_LAST     = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_END      = CNT_W'(FRAME_BITS);

  logic              sclk_d_q;
  logic              rise, fall, cs_act;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              rw_q, rw_d;
  logic [DEC_W-1:0]  addr_q, addr_d;
  logic [DATA_W-2:0] wdat_q, wdat_d;
  wr_req_t           wr_q, wr_d;
  logic              sdo_q, sdo_d;
  logic              oe_q, oe_d;
  logic [AIDX_W-1:0] a_idx;
  logic [DIDX_W-1:0] d_idx;

  assign rise   = sclk_s & ~sclk_d_q;
  assign fall   = ~sclk_s & sclk_d_q;
  assign cs_act = ~cs_n_s;
  assign a_idx  = AIDX_W'(cnt_q - CNT_W'(1));
  assign d_idx  = DIDX_W'(cnt_q - CNT_DATA0);

  always_comb begin
    cnt_d  = cnt_q;
    rw_d   = rw_q;
    addr_d = addr_q;
    wdat_d = wdat_q;
    wr_d   = '0;
    sdo_d  = sdo_q;
    oe_d   = oe_q;
    if (!cs_act) begin
      cnt_d = '0;
      oe_d  = 1'b0;
    end else begin
      if (rise && (cnt_q != CNT_END)) begin
        cnt_d = cnt_q + CNT_W'(1);
        if (cnt_q == '0) begin
          rw_d = sdi_s;
        end else if (cnt_q <= CNT_ADDR_END) begin
          addr_d[a_idx] = sdi_s;
        end else if (cnt_q == CNT_LAST) begin
          if (!rw_q) begin
            wr_d.en   = 1'b1;
            wr_d.addr = addr_q;
            wr_d.data = {sdi_s, wdat_q};
          end
        end else if (cnt_q >= CNT_DATA0) begin
          wdat_d[d_idx] = sdi_s;
        end
      end
      if (fall) begin
        if (rw_q && (cnt_q >= CNT_DATA0) && (cnt_q < CNT_END)) begin
          oe_d  = 1'b1;
          sdo_d = rd_data[d_idx];
        end else begin
          oe_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d_q <= 1'b0;
      cnt_q    <= '0;
      rw_q     <= 1'b0;
      addr_q   <= '0;
      wdat_q   <= '0;
      wr_q     <= '0;
      sdo_q    <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      sclk_d_q <= sclk_s;
      cnt_q    <= cnt_d;
      rw_q     <= rw_d;
      addr_q   <= addr_d;
      wdat_q   <= wdat_d;
      wr_q     <= wr_d;
      sdo_q    <= sdo_d;
      oe_q     <= oe_d;
    end
  end

  assign rd_addr = addr_q;
  assign wr_req  = wr_q;
  assign sdo     = sdo_q & oe_q;
  assign sdo_oe  = oe_q;

  // R10: the bit counter never runs past one frame
  p_cnt_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_END);
  // R9: a released select clears the frame
  p_cnt_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (cnt_q == '0));
  // R9: a write strobe only follows a complete write frame
  p_wr_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q.en |-> (cnt_q == CNT_END) && !rw_q);
  // R8: output drive only in the data phase of a read
  p_oe_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> rw_q && (cnt_q >= CNT_DATA0) && cs_act);
  // R12: serial data out moves only after a falling serial edge
  p_sdo_fall_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo_q) |-> $past(fall));
endmodule

// File: rtl/sra_regbank.sv
module sra_regbank
  import sra_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  wr_req_t                  wr_req,
  input  logic [DEC_W-1:0]         rd_addr,
  output logic [DATA_W-1:0]        rd_data,
  output logic [NUM_GP*DATA_W-1:0] gp_regs,
  output logic [CTL_W-1:0]         ctl
);
  logic              wr_hit, rd_hit;
  logic [SEL_W-1:0]  wr_idx, rd_idx;
  logic [NUM_GP-1:0] we_gp;
  logic              we_ctl;
  logic [DATA_W-1:0] gp_q [NUM_GP];
  logic [CTL_W-1:0]  ctl_q, ctl_d;

  // only the low index bits select; the bits above must be zero
  assign wr_hit = (wr_req.addr[DEC_W-1:SEL_W] == '0);
  assign rd_hit = (rd_addr[DEC_W-1:SEL_W] == '0);
  assign wr_idx = wr_req.addr[SEL_W-1:0];
  assign rd_idx = rd_addr[SEL_W-1:0];

  always_comb begin
    for (int i = 0; i < NUM_GP; i++) begin
      we_gp[i] = wr_req.en && wr_hit && (wr_idx == SEL_W'(i));
    end
    we_ctl = wr_req.en && wr_hit && (wr_idx == SEL_W'(CTL_IDX));
    ctl_d  = wr_req.data[CTL_W-1:0];
  end

  for (genvar g = 0; g < NUM_GP; g++) begin : g_gp
    logic [DATA_W-1:0] gp_d;
    assign gp_d = wr_req.data;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        gp_q[g] <= '0;
      else if (we_gp[g]) gp_q[g] <= gp_d;
    end
    assign gp_regs[g*DATA_W +: DATA_W] = gp_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (we_ctl) ctl_q <= ctl_d;
  end

  always_comb begin
    rd_data = '0;
    if (rd_hit) begin
      for (int i = 0; i < NUM_GP; i++) begin
        if (rd_idx == SEL_W'(i)) rd_data = gp_q[i];
      end
      if (rd_idx == SEL_W'(CTL_IDX)) rd_data = DATA_W'(ctl_q);
    end
  end

  assign ctl = ctl_q;

  // R5 / R7: writes that select no register leave the bank unchanged
  p_rsv_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req.en && (!wr_hit || (wr_idx > SEL_W'(CTL_IDX)))) |=> $stable(ctl_q) && $stable(gp_regs));
  // R5 / R7: unselected reads return zero
  p_rsv_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_hit || (rd_idx > SEL_W'(CTL_IDX))) |-> (rd_data == '0));
  // R3: upper bits of the control register read as zero
  p_ctl_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && (rd_idx == SEL_W'(CTL_IDX))) |-> (rd_data[DATA_W-1:CTL_W] == '0));
endmodule

// File: rtl/sra_serial_regs.sv
module sra_serial_regs
  import sra_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cs_n,
  input  logic                     sclk,
  input  logic                     sdi,
  output logic                     sdo,
  output logic                     sdo_oe,
  output logic [NUM_GP*DATA_W-1:0] gp_regs,
  output logic                     out1_div8,
  output logic                     out2_div8,
  output logic                     out2_en,
  output logic                     out1_en,
  output logic                     frame8k_en
);
  logic              rst_meta_q, rst_sync_q;
  logic [2:0]        pins_s;
  logic [DATA_W-1:0] rd_data;
  logic [DEC_W-1:0]  rd_addr;
  wr_req_t           wr_req;
  logic [CTL_W-1:0]  ctl;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  sra_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .d     ({cs_n, sclk, sdi}),
    .q     (pins_s)
  );

  sra_frame u_frame (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .cs_n_s  (pins_s[2]),
    .sclk_s  (pins_s[1]),
    .sdi_s   (pins_s[0]),
    .rd_data (rd_data),
    .rd_addr (rd_addr),
    .wr_req  (wr_req),
    .sdo     (sdo),
    .sdo_oe  (sdo_oe)
  );

  sra_regbank u_bank (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .wr_req  (wr_req),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .gp_regs (gp_regs),
    .ctl     (ctl)
  );

  assign out1_div8  = ctl[CB_OUT1_DIV8];
  assign out2_div8  = ctl[CB_OUT2_DIV8];
  assign out2_en    = ctl[CB_OUT2_EN];
  assign out1_en    = ctl[CB_OUT1_EN];
  assign frame8k_en = ctl[CB_FRAME8K];
endmodule

// File: tb/tb_sra_serial_regs.sv
`timescale 1ns/1ps
module tb_sra_serial_regs;
  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst_n, cs_n, sclk, sdi;
  logic        sdo, sdo_oe;
  logic [39:0] gp_regs;
  logic        out1_div8, out2_div8, out2_en, out1_en, frame8k_en;

  int nchk  = 0;
  int nfail = 0;

  always #5 clk = ~clk;

  sra_serial_regs dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .gp_regs(gp_regs),
    .out1_div8(out1_div8), .out2_div8(out2_div8), .out2_en(out2_en),
    .out1_en(out1_en), .frame8k_en(frame8k_en)
  );

  // {rw, addr[6:0], wdata[7:0], expected read[7:0], requirement number}
  localparam logic [27:0] VEC [16] = '{
    {1'b0, 7'h00, 8'hC6, 8'h00, 4'd2},   // R2 write general reg 0
    {1'b0, 7'h03, 8'h6B, 8'h00, 4'd2},   // R2 write general reg 3
    {1'b0, 7'h05, 8'hFF, 8'h00, 4'd3},   // R3 control reg, all ones
    {1'b1, 7'h00, 8'h00, 8'hC6, 4'd2},   // R2 read back, bit order R1
    {1'b1, 7'h03, 8'h00, 8'h6B, 4'd1},   // R1 address LSB first
    {1'b1, 7'h05, 8'h00, 8'h1F, 4'd3},   // R3 top bits read zero
    {1'b0, 7'h06, 8'h77, 8'h00, 4'd5},   // R5 reserved write
    {1'b1, 7'h06, 8'h00, 8'h00, 4'd5},   // R5 reserved read
    {1'b0, 7'h07, 8'h12, 8'h00, 4'd5},
    {1'b1, 7'h07, 8'h00, 8'h00, 4'd5},
    {1'b0, 7'h41, 8'h9D, 8'h00, 4'd6},   // R6 A6 set on write
    {1'b1, 7'h01, 8'h00, 8'h9D, 4'd6},
    {1'b1, 7'h41, 8'h00, 8'h9D, 4'd6},   // R6 A6 set on read
    {1'b0, 7'h0A, 8'h99, 8'h00, 4'd7},   // R7 A3 set, write ignored
    {1'b1, 7'h02, 8'h00, 8'h00, 4'd7},
    {1'b1, 7'h0B, 8'h00, 8'h00, 4'd7}    // R7 A3 set, read zero
  };

  task automatic check(input bit ok, input string req, input logic [39:0] act,
                       input logic [39:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one frame of nclk serial clocks; returns the read byte and whether
  // the drive enable followed the expected pattern (R8)
  task automatic frame(input bit rw, input logic [6:0] addr, input logic [7:0] data,
                       input int nclk, output logic [7:0] rd, output bit oe_ok);
    rd    = '0;
    oe_ok = 1'b1;
    cs_n  = 1'b0;
    wait_clk(HALF);
    for (int k = 0; k < nclk; k++) begin
      if (k == 0)       sdi = rw;
      else if (k < 8)   sdi = addr[k-1];
      else if (k < 16)  sdi = data[k-8];
      else              sdi = 1'b1;
      wait_clk(HALF);
      if (k >= 8 && k < 16) begin
        rd[k-8] = sdo;
        if (sdo_oe !== rw) oe_ok = 1'b0;
      end else if (sdo_oe !== 1'b0) begin
        oe_ok = 1'b0;
      end
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
    wait_clk(HALF);
    if (sdo_oe !== 1'b0) oe_ok = 1'b0;
    cs_n = 1'b1;
    wait_clk(HALF);
    if (sdo_oe !== 1'b0) oe_ok = 1'b0;
  endtask

  function automatic logic [4:0] ctl_pins();
    return {frame8k_en, out1_en, out2_en, out2_div8, out1_div8};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    bit         oe_ok;
    rst_n = 1'b0;
    cs_n  = 1'b1;
    sclk  = 1'b0;
    sdi   = 1'b0;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);

    // R11 reset state
    check(gp_regs == '0, "R11 gp_regs", gp_regs, 40'h0);
    check(ctl_pins() == 5'h00, "R11 control pins", 40'(ctl_pins()), 40'h0);
    check(sdo_oe == 1'b0, "R11 sdo_oe", 40'(sdo_oe), 40'h0);

    for (int v = 0; v < 16; v++) begin
      frame(VEC[v][27], VEC[v][26:20], VEC[v][19:12], 16, rd, oe_ok);
      check(oe_ok, $sformatf("R8 drive enable, vector %0d", v), 40'(oe_ok), 40'h1);
      if (VEC[v][27]) begin
        check(rd == VEC[v][11:4],
              $sformatf("R%0d R12 read data, vector %0d", VEC[v][3:0], v),
              40'(rd), 40'(VEC[v][11:4]));
      end
    end

    // R2 parallel view of the general registers
    check(gp_regs == 40'h00_6B_00_9D_C6, "R2 gp_regs", gp_regs, 40'h00_6B_00_9D_C6);

    // R4 control pin mapping
    frame(1'b0, 7'h05, 8'h0D, 16, rd, oe_ok);
    check(ctl_pins() == 5'b01101, "R4 control pins 0x0D", 40'(ctl_pins()), 40'h0D);
    frame(1'b0, 7'h05, 8'h12, 16, rd, oe_ok);
    check(ctl_pins() == 5'b10010, "R4 control pins 0x12", 40'(ctl_pins()), 40'h12);

    // R9 aborted frames commit nothing
    frame(1'b0, 7'h05, 8'h0D, 15, rd, oe_ok);
    check(ctl_pins() == 5'b10010, "R9 aborted control write", 40'(ctl_pins()), 40'h12);
    frame(1'b0, 7'h04, 8'hAB, 12, rd, oe_ok);
    frame(1'b1, 7'h04, 8'h00, 16, rd, oe_ok);
    check(rd == 8'h00, "R9 aborted general write", 40'(rd), 40'h0);

    // R10 extra clocks ignored
    frame(1'b0, 7'h02, 8'h71, 20, rd, oe_ok);
    check(oe_ok, "R10 R8 long write frame", 40'(oe_ok), 40'h1);
    check(gp_regs[23:16] == 8'h71, "R10 long write", 40'(gp_regs[23:16]), 40'h71);
    frame(1'b1, 7'h02, 8'h00, 20, rd, oe_ok);
    check(rd == 8'h71, "R10 long read", 40'(rd), 40'h71);
    check(oe_ok, "R10 R8 long read frame", 40'(oe_ok), 40'h1);

    // R11 reset during operation
    rst_n = 1'b0;
    wait_clk(3);
    check(gp_regs == '0, "R11 gp_regs after reset", gp_regs, 40'h0);
    check(ctl_pins() == 5'h00, "R11 pins after reset", 40'(ctl_pins()), 40'h0);
    rst_n = 1'b1;
    wait_clk(4);
    frame(1'b1, 7'h00, 8'h00, 16, rd, oe_ok);
    check(rd == 8'h00, "R11 reg 0 after reset", 40'(rd), 40'h0);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule